// File: doc/BRIEF.md
# Packed Pixel to 24-bit RGB Translator

This block takes one pixel word in a packed format and turns it into a 24-bit truecolour value: red on bits 23:16, green on 15:8 and blue on 7:0. A four-bit format code picks how the word is read. Direct formats are supported: monochrome, one bit per channel, one bit per channel plus an intensity bit, grayscale at 2, 3, 4 and 8 bits, 8-bit 3-3-2, 16-bit 5-6-5 and 24-bit truecolour held in a 32-bit word. Palette-indexed codes are accepted. There is no colour table in the block, so they give black.

The result is registered. A pixel and code presented at one rising edge appear on the output after that edge and stay until the next edge. The block sits in a video pipeline between the pixel fetch stage and the sync and DAC stages. Channels narrower than 8 bits are widened by repeating their top bits into the low bits, so an all-ones field gives 0xFF.

Top module: `pxc_translator`

## Requirements
- R1: The output register loads the translation of `fmt_code` and `pix_in` sampled at a rising edge and holds it until the next edge, with red in [23:16], green in [15:8] and blue in [7:0].
- R2: While `rst_n` is low at a rising edge, `rgb_out` becomes 0x000000.
- R3: Code 0 (monochrome) reads pix_in[0]: 0 gives 0x000000 and 1 gives 0xFFFFFF.
- R4: Code 4 (one bit per channel) reads red from bit 2, green from bit 1 and blue from bit 0. A set bit gives 0xFF on that channel and a clear bit gives 0x00.
- R5: Code 7 (intensity RGB) reads intensity from bit 3 and red, green and blue from bits 2, 1 and 0. With intensity 1, a set channel gives 0xFF and a clear one 0x55. With intensity 0, a set channel gives 0xAA and a clear one 0x00, except that red=1, green=1, blue=0 gives green 0x55.
- R6: Codes 2, 5, 8 and 11 are grayscale using the low 2, 3, 4 and 8 bits. All three channels are equal. The level runs from 0x00 at value 0 to 0xFF at the all-ones value: the 2-bit code gives v×0x55, the 4-bit code v×0x11, the 3-bit code round-down of (v×255+3)/7, and the 8-bit code v.
- R7: Code 10 (3-3-2) takes red from [7:5], green from [4:2] and blue from [1:0], each widened by repeating its top bits.
- R8: Code 12 (5-6-5) takes red from [15:11], green from [10:5] and blue from [4:0], each widened by repeating its top bits.
- R9: Code 13 copies pix_in[23:0] to the output. Bits 31:24 have no effect.
- R10: The palette-indexed codes 1, 3, 6 and 9 give 0x000000 for any pixel.
- R11: The unassigned codes 14 and 15 give 0x000000 for any pixel.
- R12: In every code, pixel bits above the ones the format reads have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_code | input | 4 | Pixel format code (0 to 13; 14 and 15 are unassigned) |
| pix_in | input | 32 | Packed pixel word |
| rgb_out | output | 24 | Registered truecolour result |

## Verification
The assertions assume that `fmt_code` and `pix_in` are always at defined levels at the rising edge. They also assume that the checks run one edge after the stimulus, with reset held high over both edges. The bench drives every input at the falling edge, so each value is settled a half period before it is sampled. Reset is only released or asserted at falling edges, away from any sampled vector. Every code, including the unassigned ones, is swept over all 256 values of the low byte. Each code also gets wide words whose upper bits are set, so that the bits the format does not read are toggled.

// File: rtl/pxc_pkg.sv
// Shared definitions for the pixel translator: format codes and
// channel widening helpers. Assumes 8-bit output channels.
package pxc_pkg;

    localparam int CODE_W = 4;
    localparam int CHAN_W = 8;
    localparam int RGB_W  = 3 * CHAN_W;

    typedef enum logic [CODE_W-1:0] {
        FMT_MONO    = 4'd0,
        FMT_IDX2    = 4'd1,
        FMT_GRAY2   = 4'd2,
        FMT_IDX3    = 4'd3,
        FMT_RGB111  = 4'd4,
        FMT_GRAY3   = 4'd5,
        FMT_IDX4    = 4'd6,
        FMT_RGBI    = 4'd7,
        FMT_GRAY4   = 4'd8,
        FMT_IDX8    = 4'd9,
        FMT_RGB332  = 4'd10,
        FMT_GRAY8   = 4'd11,
        FMT_RGB565  = 4'd12,
        FMT_RGB888  = 4'd13
    } fmt_e;

    // Widen a 2-bit field by repetition
    function automatic logic [7:0] widen2(input logic [1:0] v);
        return {v, v, v, v};
    endfunction

    // Widen a 3-bit field by repetition
    function automatic logic [7:0] widen3(input logic [2:0] v);
        return {v, v, v[2:1]};
    endfunction

    // Widen a 5-bit field by repetition
    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    // Widen a 6-bit field by repetition
    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/pxc_gray.sv
// Grayscale level expander. Picks the 2, 3, 4 or 8-bit level from the
// low byte and widens it to one 8-bit channel value. Assumes the caller
// only uses the result for the grayscale format codes.
module pxc_gray
    import pxc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [7:0]        low_i,
    output logic [CHAN_W-1:0] level_o
);

    // Select the width-specific expansion
    always_comb begin
        unique case (code_i)
            FMT_GRAY2: level_o = widen2(low_i[1:0]);
            FMT_GRAY3: level_o = widen3(low_i[2:0]);
            FMT_GRAY4: level_o = {low_i[3:0], low_i[3:0]};
            default:   level_o = low_i;
        endcase
    end

endmodule

// File: rtl/pxc_rgbi.sv
// Four-bit intensity RGB decoder. Bit 3 is intensity, bits 2..0 are
// red, green, blue. Dark yellow is shifted towards brown by lowering
// its green channel to the bright-off level.
module pxc_rgbi
    import pxc_pkg::*;
(
    input  logic [3:0]       nib_i,
    output logic [RGB_W-1:0] rgb_o
);

    localparam logic [7:0] LVL_ON_HI  = 8'hFF;
    localparam logic [7:0] LVL_OFF_HI = 8'h55;
    localparam logic [7:0] LVL_ON_LO  = 8'hAA;
    localparam logic [7:0] LVL_OFF_LO = 8'h00;

    logic [CHAN_W-1:0] chan [3];

    // Map each channel bit to its level
    for (genvar c = 0; c < 3; c++) begin : g_chan
        assign chan[c] = nib_i[3] ? (nib_i[c] ? LVL_ON_HI : LVL_OFF_HI)
                                  : (nib_i[c] ? LVL_ON_LO : LVL_OFF_LO);
    end

    // Assemble channels, applying the dark-yellow adjustment
    always_comb begin
        rgb_o = {chan[2], chan[1], chan[0]};
        if (nib_i == 4'b0110) begin
            rgb_o[15:8] = LVL_OFF_HI;
        end
    end

endmodule

// File: rtl/pxc_packed.sv
// Decoder for the packed direct-colour formats: monochrome, 1-1-1,
// 3-3-2, 5-6-5 and 24-bit truecolour. All results are computed in
// parallel; the top level selects one of them.
module pxc_packed
    import pxc_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] pix_i,
    output logic [RGB_W-1:0] mono_o,
    output logic [RGB_W-1:0] rgb111_o,
    output logic [RGB_W-1:0] rgb332_o,
    output logic [RGB_W-1:0] rgb565_o,
    output logic [RGB_W-1:0] rgb888_o
);

    // Monochrome: bit 0 selects black or white
    assign mono_o   = {RGB_W{pix_i[0]}};

    // One bit per channel, red on bit 2
    assign rgb111_o = {{CHAN_W{pix_i[2]}}, {CHAN_W{pix_i[1]}}, {CHAN_W{pix_i[0]}}};

    // 3-3-2 channel split
    assign rgb332_o = {widen3(pix_i[7:5]), widen3(pix_i[4:2]), widen2(pix_i[1:0])};

    // 5-6-5 channel split
    assign rgb565_o = {widen5(pix_i[15:11]), widen6(pix_i[10:5]), widen5(pix_i[4:0])};

    // Truecolour: low 24 bits pass through
    assign rgb888_o = pix_i[RGB_W-1:0];

endmodule

// File: rtl/pxc_translator.sv
// Pixel format translator top. Decodes a packed pixel word according to
// a format code and registers the 24-bit RGB result with one cycle of
// latency. Indexed and unassigned codes yield black. Assumes PIX_W is
// at least 24 and a synchronous active-low reset.
module pxc_translator
    import pxc_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] fmt_code,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [RGB_W-1:0]  rgb_out
);

    logic [RGB_W-1:0]  mono_w, rgb111_w, rgb332_w, rgb565_w, rgb888_w, rgbi_w;
    logic [CHAN_W-1:0] gray_w;
    logic [RGB_W-1:0]  next_rgb;

    pxc_packed #(.PIX_W(PIX_W)) u_packed (
        .pix_i    (pix_in),
        .mono_o   (mono_w),
        .rgb111_o (rgb111_w),
        .rgb332_o (rgb332_w),
        .rgb565_o (rgb565_w),
        .rgb888_o (rgb888_w)
    );

    pxc_rgbi u_rgbi (
        .nib_i (pix_in[3:0]),
        .rgb_o (rgbi_w)
    );

    pxc_gray u_gray (
        .code_i  (fmt_code),
        .low_i   (pix_in[7:0]),
        .level_o (gray_w)
    );

    // Choose the decoded colour for the current format code
    always_comb begin
        unique case (fmt_code)
            FMT_MONO:   next_rgb = mono_w;
            FMT_RGB111: next_rgb = rgb111_w;
            FMT_RGBI:   next_rgb = rgbi_w;
            FMT_GRAY2, FMT_GRAY3, FMT_GRAY4, FMT_GRAY8:
                        next_rgb = {gray_w, gray_w, gray_w};
            FMT_RGB332: next_rgb = rgb332_w;
            FMT_RGB565: next_rgb = rgb565_w;
            FMT_RGB888: next_rgb = rgb888_w;
            default:    next_rgb = '0;
        endcase
    end

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out <= '0;
        end else begin
            rgb_out <= next_rgb;
        end
    end

endmodule

// File: rtl/pxc_translator_chk.sv
// Property checker for pxc_translator, attached by bind. Relates the
// registered output to the inputs sampled one edge earlier.
module pxc_translator_chk
    import pxc_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] fmt_code,
    input logic [PIX_W-1:0]  pix_in,
    input logic [RGB_W-1:0]  rgb_out
);

    // R10
    idx_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 4'd1 || fmt_code == 4'd3 || fmt_code == 4'd6 || fmt_code == 4'd9)
        |=> rgb_out == '0);

    // R11
    undef_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code >= 4'd14) |=> rgb_out == '0);

    // R3
    mono_bw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 4'd0) |=> (rgb_out == 24'h000000 || rgb_out == 24'hFFFFFF));

    // R6
    gray_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 4'd2 || fmt_code == 4'd5 || fmt_code == 4'd8 || fmt_code == 4'd11)
        |=> (rgb_out[23:16] == rgb_out[15:8] && rgb_out[15:8] == rgb_out[7:0]));

    // R9
    true_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_code == 4'd13) |=> rgb_out == $past(pix_in[23:0]));

endmodule

bind pxc_translator pxc_translator_chk #(.PIX_W(PIX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_code (fmt_code),
    .pix_in   (pix_in),
    .rgb_out  (rgb_out)
);

// File: tb/sim_pxc_translator.sv
module sim_pxc_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fmt_code = '0;
    logic [31:0] pix_in = '0;
    logic [23:0] rgb_out;

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pxc_translator u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_code (fmt_code),
        .pix_in   (pix_in),
        .rgb_out  (rgb_out)
    );

    function automatic string req_of(input int code);
        case (code)
            0: return "R3";
            4: return "R4";
            7: return "R5";
            2, 5, 8, 11: return "R6";
            10: return "R7";
            12: return "R8";
            13: return "R9";
            1, 3, 6, 9: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int rep(input int v, input int bits);
        int acc = 0;
        int filled = 0;
        while (filled < 8) begin
            acc = (acc << bits) | v;
            filled += bits;
        end
        return (acc >> (filled - 8)) & 255;
    endfunction

    // Behavioural model of the requirements
    function automatic logic [23:0] model(input int code, input logic [31:0] p);
        int r, g, b, v;
        r = 0; g = 0; b = 0;
        case (code)
            0: begin r = p[0] ? 255 : 0; g = r; b = r; end
            4: begin r = p[2] ? 255 : 0; g = p[1] ? 255 : 0; b = p[0] ? 255 : 0; end
            7: begin
                r = p[3] ? (p[2] ? 255 : 85) : (p[2] ? 170 : 0);
                g = p[3] ? (p[1] ? 255 : 85) : (p[1] ? 170 : 0);
                b = p[3] ? (p[0] ? 255 : 85) : (p[0] ? 170 : 0);
                if (p[3:0] == 4'b0110) g = 85;
            end
            2: begin v = p[1:0] * 85; r = v; g = v; b = v; end
            5: begin v = (int'(p[2:0]) * 255 + 3) / 7; r = v; g = v; b = v; end
            8: begin v = p[3:0] * 17; r = v; g = v; b = v; end
            11: begin v = p[7:0]; r = v; g = v; b = v; end
            10: begin r = rep(p[7:5], 3); g = rep(p[4:2], 3); b = rep(p[1:0], 2); end
            12: begin r = rep(p[15:11], 5); g = rep(p[10:5], 6); b = rep(p[4:0], 5); end
            13: begin r = p[23:16]; g = p[15:8]; b = p[7:0]; end
            default: ;
        endcase
        return {r[7:0], g[7:0], b[7:0]};
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        vec_cnt++;
        if (rgb_out !== exp) begin
            bad_cnt++;
            $display("FAIL %s: rgb_out=%06h expected=%06h (code %0d pix %08h)",
                     req, rgb_out, exp, fmt_code, pix_in);
        end
    endtask

    // Apply one vector at the falling edge, check one edge later (R1)
    task automatic apply(input int code, input logic [31:0] p);
        logic [23:0] exp;
        fmt_code = code[3:0];
        pix_in = p;
        exp = model(code, p);
        @(negedge clk);
        check(req_of(code), exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        lfsr = 32'hC0FFEE01;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", 24'h000000);
        rst_n = 1'b1;
        // R1 and R3..R11: every code over the full low byte
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 256; v++) begin
                apply(c, 32'(v));
            end
        end
        // R12: upper bits set in every code
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 40; k++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                apply(c, lfsr | 32'hFF00_0000);
                apply(c, lfsr);
            end
            apply(c, 32'hFFFF_FFFF);
        end
        // R2: reset mid-stream clears a white output
        apply(0, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2", 24'h000000);
        rst_n = 1'b1;
        apply(13, 32'h00AB_CDEF);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule